// File: doc/BRIEF.md
# Accumulator ALU Execute Unit

This block is the data-path execute stage of a small 8-bit accumulator processor that uses 12-bit instruction words. Each cycle it may be given one instruction word with a valid strobe. It decodes the word, reads one operand byte from an external register file, and computes a result. The result goes either into the working register W held inside the block, or back to the register file through a write port. The block also keeps the carry, digit-carry and zero flags, and updates each of them according to the opcode.

The register file read is combinational. The block presents a read address taken from the instruction, and the file returns the byte in the same cycle. The file write address, data and enable are combinational outputs, so the register file captures them on the clock edge that ends the instruction. W and the flags change on that same edge. A skip output is raised during the instruction cycle when a bit test or a count-and-test instruction decides that the next instruction should be skipped. The sequencer outside the block acts on it. Program flow, timers and pins belong to other blocks.

Top module: `acc_alu_exec`

## Requirements
- R1: After reset, W is 0x00, carry, digit-carry and zero are 0, and with valid_i low wr_en_o and skip_o are 0.
- R2: For file-operand words, rd_addr_o and wr_addr_o equal instruction bits 4..0. Bit 5 selects the destination: 0 loads W at the clock edge, and 1 raises wr_en_o in the same cycle with the result on wr_data_o while W keeps its value.
- R3: Bits 11..6 = 000111 add W to the operand, and 000010 computes operand minus W. Both update C, DC and Z. For the add, C is the carry out of bit 7 and DC the carry out of bit 3. For the subtraction, C is 1 when no borrow occurs and DC is 1 when no borrow occurs out of the low nibble.
- R4: Bits 11..6 = 000101 (AND with W), 000100 (OR with W), 000110 (XOR with W), 001001 (complement), 001010 (increment), 000011 (decrement) and 001000 (pass operand) update only Z, which is set when the result is 0x00.
- R5: Bits 11..6 = 001101 rotate left through C: C enters bit 0 and bit 7 goes to C. 001100 rotates right through C: C enters bit 7 and bit 0 goes to C. Only C changes among the flags.
- R6: Bits 11..6 = 001110 exchange the two nibbles of the operand. Word 0000001fffff writes W to file address fffff. Neither changes any flag.
- R7: Word 0000011fffff writes 0x00 to the file and sets Z. The fixed word 0x040 loads W with 0x00 and sets Z. C and DC are kept.
- R8: Bits 11..8 = 0100 clear, and 0101 set, the operand bit whose index is given by bits 7..5. The byte is written back to the file address in bits 4..0 and no flag changes.
- R9: Bits 11..8 = 0110 raise skip_o when the selected bit of the read value is 0, and 0111 raise skip_o when it is 1. Nothing is written and no flag changes.
- R10: Bits 11..6 = 001011 (decrement) and 001111 (increment) route the result by bit 5 as in R2. They change no flag, and they raise skip_o when the result is 0x00.
- R11: With an 8-bit literal in bits 7..0, top nibble 1100 loads W with the literal and changes no flag. Top nibbles 1110 (AND), 1101 (OR) and 1111 (XOR) combine the literal with W into W and update only Z.
- R12: With valid_i low, or with a word outside R2 to R11 (the all-zero word, other words with bits 11..6 = 000000 or 000001, or top nibbles 1000 to 1011), nothing is written, skip_o stays 0, and W and the flags keep their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Instruction word is valid this cycle |
| instr_i | input | 12 | Instruction word |
| rd_addr_o | output | 5 | Register file read address |
| rd_data_i | input | 8 | Register file read data, same cycle |
| wr_addr_o | output | 5 | Register file write address |
| wr_data_o | output | 8 | Register file write data |
| wr_en_o | output | 1 | Register file write enable, captured at the clock edge |
| w_o | output | 8 | Working register W |
| c_o | output | 1 | Carry flag |
| dc_o | output | 1 | Digit-carry flag |
| z_o | output | 1 | Zero flag |
| skip_o | output | 1 | Skip the next instruction |

## Verification
The bench builds the block with its default 8-bit data path and 5-bit file address. At that size every operand byte can be reached. Each arithmetic, logic, rotate, swap and count-and-test opcode is swept over all 256 operand values, under four W values and with both destinations. Bit set, clear and test run over all eight indices and every operand, and the literal forms cover every literal under each W value. This brings the carry and borrow edges at 0x00, 0x0F, 0x80 and 0xFF, and the equal-operand zero results, within reach.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;

  typedef enum logic [4:0] {
    OP_NOP, OP_ADD, OP_SUB, OP_AND, OP_IOR, OP_XOR, OP_COM, OP_INC, OP_DEC,
    OP_MOVF, OP_INCSZ, OP_DECSZ, OP_RLF, OP_RRF, OP_SWAP, OP_MOVWF, OP_CLRF,
    OP_CLRW, OP_BCF, OP_BSF, OP_BTSC, OP_BTSS, OP_MOVL, OP_ANDL, OP_IORL,
    OP_XORL
  } op_e;

  typedef struct packed {
    logic c;
    logic dc;
    logic z;
  } flags_t;

endpackage

// File: rtl/acc_decode.sv
module acc_decode
  import acc_alu_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 5,
  localparam int INSTR_W = DATA_W + 4,
  localparam int BIT_W = $clog2(DATA_W)
) (
  input  logic [INSTR_W-1:0] instr_i,
  output op_e                op_o,
  output logic               wr_w_o,
  output logic               wr_file_o,
  output logic [BIT_W-1:0]   bit_idx_o,
  output logic [DATA_W-1:0]  lit_o
);

  logic [3:0]        top4;
  logic [5:0]        code6;
  logic              dst;
  logic [ADDR_W-1:0] faddr;

  assign top4      = instr_i[INSTR_W-1 -: 4];
  assign code6     = instr_i[INSTR_W-1 -: 6];
  assign dst       = instr_i[ADDR_W];
  assign faddr     = instr_i[ADDR_W-1:0];
  assign bit_idx_o = instr_i[ADDR_W +: BIT_W];
  assign lit_o     = instr_i[DATA_W-1:0];

  always_comb begin
    op_o      = OP_NOP;
    wr_w_o    = 1'b0;
    wr_file_o = 1'b0;
    unique case (top4)
      4'b0000, 4'b0001, 4'b0010, 4'b0011: begin
        // byte ops: default routing by destination bit
        wr_w_o    = ~dst;
        wr_file_o = dst;
        unique case (code6)
          6'b000000: begin
            wr_w_o = 1'b0;
            if (dst) op_o = OP_MOVWF;
            else     wr_file_o = 1'b0;
          end
          6'b000001: begin
            if (dst) begin
              op_o = OP_CLRF;
            end else if (faddr == '0) begin
              op_o   = OP_CLRW;
              wr_w_o = 1'b1;
            end else begin
              wr_w_o = 1'b0;
            end
          end
          6'b000010: op_o = OP_SUB;
          6'b000011: op_o = OP_DEC;
          6'b000100: op_o = OP_IOR;
          6'b000101: op_o = OP_AND;
          6'b000110: op_o = OP_XOR;
          6'b000111: op_o = OP_ADD;
          6'b001000: op_o = OP_MOVF;
          6'b001001: op_o = OP_COM;
          6'b001010: op_o = OP_INC;
          6'b001011: op_o = OP_DECSZ;
          6'b001100: op_o = OP_RRF;
          6'b001101: op_o = OP_RLF;
          6'b001110: op_o = OP_SWAP;
          6'b001111: op_o = OP_INCSZ;
          default: begin
            wr_w_o    = 1'b0;
            wr_file_o = 1'b0;
          end
        endcase
      end
      4'b0100: begin op_o = OP_BCF; wr_file_o = 1'b1; end
      4'b0101: begin op_o = OP_BSF; wr_file_o = 1'b1; end
      4'b0110: op_o = OP_BTSC;
      4'b0111: op_o = OP_BTSS;
      4'b1100: begin op_o = OP_MOVL; wr_w_o = 1'b1; end
      4'b1101: begin op_o = OP_IORL; wr_w_o = 1'b1; end
      4'b1110: begin op_o = OP_ANDL; wr_w_o = 1'b1; end
      4'b1111: begin op_o = OP_XORL; wr_w_o = 1'b1; end
      default: ;
    endcase
  end

endmodule

// File: rtl/acc_alu.sv
module acc_alu
  import acc_alu_pkg::*;
#(
  parameter int DATA_W = 8,
  localparam int BIT_W = $clog2(DATA_W),
  localparam int HALF = DATA_W / 2
) (
  input  op_e               op_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] w_i,
  input  logic              c_i,
  input  logic [BIT_W-1:0]  bit_idx_i,
  input  logic [DATA_W-1:0] lit_i,
  output logic [DATA_W-1:0] res_o,
  output flags_t            flg_o,
  output flags_t            upd_o,
  output logic              skip_o
);

  localparam logic [DATA_W:0] ONE_F = {{DATA_W{1'b0}}, 1'b1};
  localparam logic [HALF:0]   ONE_H = {{HALF{1'b0}}, 1'b1};
  localparam logic [DATA_W-1:0] ONE_D = {{(DATA_W-1){1'b0}}, 1'b1};

  logic [DATA_W:0]   add_full, sub_full;
  logic [HALF:0]     add_low, sub_low;
  logic [DATA_W-1:0] bmask;
  logic              bsel;

  // subtraction as operand + ~W + 1: carry out means no borrow
  assign add_full = {1'b0, a_i} + {1'b0, w_i};
  assign sub_full = {1'b0, a_i} + {1'b0, ~w_i} + ONE_F;
  assign add_low  = {1'b0, a_i[HALF-1:0]} + {1'b0, w_i[HALF-1:0]};
  assign sub_low  = {1'b0, a_i[HALF-1:0]} + {1'b0, ~w_i[HALF-1:0]} + ONE_H;
  assign bmask    = ONE_D << bit_idx_i;
  assign bsel     = a_i[bit_idx_i];

  always_comb begin
    res_o  = a_i;
    flg_o  = '0;
    upd_o  = '0;
    skip_o = 1'b0;
    unique case (op_i)
      OP_ADD: begin
        res_o  = add_full[DATA_W-1:0];
        flg_o.c  = add_full[DATA_W];
        flg_o.dc = add_low[HALF];
        upd_o  = '{c: 1'b1, dc: 1'b1, z: 1'b1};
      end
      OP_SUB: begin
        res_o  = sub_full[DATA_W-1:0];
        flg_o.c  = sub_full[DATA_W];
        flg_o.dc = sub_low[HALF];
        upd_o  = '{c: 1'b1, dc: 1'b1, z: 1'b1};
      end
      OP_AND:  begin res_o = a_i & w_i;  upd_o.z = 1'b1; end
      OP_IOR:  begin res_o = a_i | w_i;  upd_o.z = 1'b1; end
      OP_XOR:  begin res_o = a_i ^ w_i;  upd_o.z = 1'b1; end
      OP_COM:  begin res_o = ~a_i;       upd_o.z = 1'b1; end
      OP_INC:  begin res_o = a_i + ONE_D; upd_o.z = 1'b1; end
      OP_DEC:  begin res_o = a_i - ONE_D; upd_o.z = 1'b1; end
      OP_MOVF: begin res_o = a_i;        upd_o.z = 1'b1; end
      OP_INCSZ: begin
        res_o  = a_i + ONE_D;
        skip_o = (res_o == '0);
      end
      OP_DECSZ: begin
        res_o  = a_i - ONE_D;
        skip_o = (res_o == '0);
      end
      OP_RLF: begin
        res_o   = {a_i[DATA_W-2:0], c_i};
        flg_o.c = a_i[DATA_W-1];
        upd_o.c = 1'b1;
      end
      OP_RRF: begin
        res_o   = {c_i, a_i[DATA_W-1:1]};
        flg_o.c = a_i[0];
        upd_o.c = 1'b1;
      end
      OP_SWAP:  res_o = {a_i[HALF-1:0], a_i[DATA_W-1:HALF]};
      OP_MOVWF: res_o = w_i;
      OP_CLRF, OP_CLRW: begin res_o = '0; upd_o.z = 1'b1; end
      OP_BCF:  res_o = a_i & ~bmask;
      OP_BSF:  res_o = a_i | bmask;
      OP_BTSC: skip_o = ~bsel;
      OP_BTSS: skip_o = bsel;
      OP_MOVL: res_o = lit_i;
      OP_ANDL: begin res_o = w_i & lit_i; upd_o.z = 1'b1; end
      OP_IORL: begin res_o = w_i | lit_i; upd_o.z = 1'b1; end
      OP_XORL: begin res_o = w_i ^ lit_i; upd_o.z = 1'b1; end
      default: ;
    endcase
    flg_o.z = (res_o == '0);
  end

endmodule

// File: rtl/acc_state.sv
module acc_state
  import acc_alu_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              wr_w_i,
  input  logic [DATA_W-1:0] res_i,
  input  flags_t            flg_i,
  input  flags_t            upd_i,
  output logic [DATA_W-1:0] w_o,
  output flags_t            flg_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      w_o   <= '0;
      flg_o <= '0;
    end else if (en_i) begin
      if (wr_w_i)   w_o      <= res_i;
      if (upd_i.c)  flg_o.c  <= flg_i.c;
      if (upd_i.dc) flg_o.dc <= flg_i.dc;
      if (upd_i.z)  flg_o.z  <= flg_i.z;
    end
  end

  a_r12_w_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(w_o));
  a_r12_flags_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(flg_o));

endmodule

// File: rtl/acc_alu_exec.sv
module acc_alu_exec
  import acc_alu_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 5,
  localparam int INSTR_W = DATA_W + 4,
  localparam int BIT_W = $clog2(DATA_W)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               valid_i,
  input  logic [INSTR_W-1:0] instr_i,
  output logic [ADDR_W-1:0]  rd_addr_o,
  input  logic [DATA_W-1:0]  rd_data_i,
  output logic [ADDR_W-1:0]  wr_addr_o,
  output logic [DATA_W-1:0]  wr_data_o,
  output logic               wr_en_o,
  output logic [DATA_W-1:0]  w_o,
  output logic               c_o,
  output logic               dc_o,
  output logic               z_o,
  output logic               skip_o
);

  op_e               op;
  logic              wr_w, wr_file, alu_skip;
  logic [BIT_W-1:0]  bit_idx;
  logic [DATA_W-1:0] lit, res, w_q;
  flags_t            alu_flg, alu_upd, flg_q;

  acc_decode #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_decode (
    .instr_i   (instr_i),
    .op_o      (op),
    .wr_w_o    (wr_w),
    .wr_file_o (wr_file),
    .bit_idx_o (bit_idx),
    .lit_o     (lit)
  );

  acc_alu #(.DATA_W(DATA_W)) u_alu (
    .op_i      (op),
    .a_i       (rd_data_i),
    .w_i       (w_q),
    .c_i       (flg_q.c),
    .bit_idx_i (bit_idx),
    .lit_i     (lit),
    .res_o     (res),
    .flg_o     (alu_flg),
    .upd_o     (alu_upd),
    .skip_o    (alu_skip)
  );

  acc_state #(.DATA_W(DATA_W)) u_state (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (valid_i),
    .wr_w_i (wr_w),
    .res_i  (res),
    .flg_i  (alu_flg),
    .upd_i  (alu_upd),
    .w_o    (w_q),
    .flg_o  (flg_q)
  );

  assign rd_addr_o = instr_i[ADDR_W-1:0];
  assign wr_addr_o = instr_i[ADDR_W-1:0];
  assign wr_data_o = res;
  assign wr_en_o   = valid_i & wr_file;
  assign skip_o    = valid_i & alu_skip;
  assign w_o       = w_q;
  assign c_o       = flg_q.c;
  assign dc_o      = flg_q.dc;
  assign z_o       = flg_q.z;

  a_r2_file_dest_keeps_w: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |=> $stable(w_o));
  a_r5_rotate_only_c: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && (op == OP_RLF || op == OP_RRF)) |=> ($stable(z_o) && $stable(dc_o)));
  a_r6_swap_no_flags: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && (op == OP_SWAP || op == OP_MOVWF)) |=> $stable({c_o, dc_o, z_o}));
  a_r7_clrw_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op == OP_CLRW) |=> (w_o == '0 && z_o));
  a_r8_single_bit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_o && (op == OP_BCF || op == OP_BSF)) |-> ($countones(wr_data_o ^ rd_data_i) <= 1));
  a_r9_skip_source: assert property (@(posedge clk_i) disable iff (!rst_ni)
    skip_o |-> (op == OP_BTSC || op == OP_BTSS || op == OP_INCSZ || op == OP_DECSZ));
  a_r10_skipz_no_flags: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && (op == OP_INCSZ || op == OP_DECSZ)) |=> $stable({c_o, dc_o, z_o}));

endmodule

// File: tb/acc_alu_exec_tb.sv
module acc_alu_exec_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid = 1'b0;
  logic [11:0] instr = '0;
  logic [7:0]  rd_data = '0;
  logic [4:0]  rd_addr_o, wr_addr_o;
  logic [7:0]  wr_data_o, w_o;
  logic        wr_en_o, c_o, dc_o, z_o, skip_o;

  int tests = 0;
  int fails = 0;

  // bench model state and expectations
  logic [7:0] m_w = '0;
  logic       m_c = 1'b0, m_dc = 1'b0, m_z = 1'b0;
  logic       e_wen, e_skip;
  logic [7:0] e_wd;
  string      req;

  always #4 clk = ~clk;

  acc_alu_exec dut_i (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .instr_i(instr),
    .rd_addr_o(rd_addr_o), .rd_data_i(rd_data), .wr_addr_o(wr_addr_o),
    .wr_data_o(wr_data_o), .wr_en_o(wr_en_o), .w_o(w_o), .c_o(c_o),
    .dc_o(dc_o), .z_o(z_o), .skip_o(skip_o)
  );

  task automatic model(input logic [11:0] ins, input logic [7:0] a);
    logic [3:0] hi = ins[11:8];
    logic [5:0] c6 = ins[11:6];
    logic       d = ins[5];
    logic [7:0] k = ins[7:0];
    logic [2:0] b = ins[7:5];
    logic [7:0] r = '0;
    logic       nc;
    logic       routed = 1'b0;
    int         s;
    e_wen = 1'b0; e_skip = 1'b0; e_wd = '0; req = "R12";
    if (hi >= 4'hC) begin
      req = "R11";
      case (hi)
        4'hC: m_w = k;
        4'hD: begin m_w = m_w | k; m_z = (m_w == 0); end
        4'hE: begin m_w = m_w & k; m_z = (m_w == 0); end
        default: begin m_w = m_w ^ k; m_z = (m_w == 0); end
      endcase
    end else if (hi >= 4'h4 && hi <= 4'h7) begin
      if (hi == 4'h4) begin req = "R8"; e_wen = 1; e_wd = a & ~(8'd1 << b); end
      else if (hi == 4'h5) begin req = "R8"; e_wen = 1; e_wd = a | (8'd1 << b); end
      else if (hi == 4'h6) begin req = "R9"; e_skip = (a[b] == 1'b0); end
      else begin req = "R9"; e_skip = (a[b] == 1'b1); end
    end else if (hi <= 4'h3) begin
      case (c6)
        6'd0: if (d) begin req = "R6"; e_wen = 1; e_wd = m_w; end
        6'd1: if (d) begin req = "R7"; e_wen = 1; e_wd = 0; m_z = 1; end
              else if (ins == 12'h040) begin req = "R7"; m_w = 0; m_z = 1; end
        6'd2: begin
          req = "R3"; routed = 1;
          s = int'(a) - int'(m_w); r = 8'(s);
          m_c = (a >= m_w); m_dc = (a[3:0] >= m_w[3:0]); m_z = (r == 0);
        end
        6'd7: begin
          req = "R3"; routed = 1;
          s = int'(a) + int'(m_w); r = 8'(s);
          m_c = (s > 255); m_dc = (int'(a[3:0]) + int'(m_w[3:0]) > 15); m_z = (r == 0);
        end
        6'd3, 6'd4, 6'd5, 6'd6, 6'd8, 6'd9, 6'd10: begin
          req = "R4"; routed = 1;
          case (c6)
            6'd3: r = a - 8'd1;
            6'd4: r = a | m_w;
            6'd5: r = a & m_w;
            6'd6: r = a ^ m_w;
            6'd8: r = a;
            6'd9: r = 8'hFF - a;
            default: r = a + 8'd1;
          endcase
          m_z = (r == 0);
        end
        6'd11, 6'd15: begin
          req = "R10"; routed = 1;
          r = (c6 == 6'd11) ? a - 8'd1 : a + 8'd1;
          e_skip = (r == 0);
        end
        6'd12: begin req = "R5"; routed = 1; nc = a[0]; r = (a / 2) + (m_c ? 8'h80 : 8'h00); m_c = nc; end
        6'd13: begin req = "R5"; routed = 1; nc = a[7]; r = (a * 2) + {7'd0, m_c}; m_c = nc; end
        6'd14: begin req = "R6"; routed = 1; r = (a * 16) + (a / 16); end
        default: ;
      endcase
      if (routed) begin
        if (d) begin e_wen = 1; e_wd = r; end
        else m_w = r;
      end
    end
  endtask

  task automatic run(input logic [11:0] ins, input logic [7:0] a, input logic v);
    logic ok;
    @(negedge clk);
    instr = ins; rd_data = a; valid = v;
    if (v) model(ins, a);
    else begin e_wen = 0; e_skip = 0; e_wd = 0; req = "R12"; end
    #1;
    tests++;
    ok = (wr_en_o === e_wen) && (skip_o === e_skip) && (rd_addr_o === ins[4:0]) &&
         (!e_wen || (wr_data_o === e_wd && wr_addr_o === ins[4:0]));
    if (!ok) begin
      fails++;
      $display("FAIL %s ports instr=%h a=%h: got wen=%b wd=%h wa=%h ra=%h skip=%b, exp wen=%b wd=%h wa=%h skip=%b",
               req, ins, a, wr_en_o, wr_data_o, wr_addr_o, rd_addr_o, skip_o, e_wen, e_wd, ins[4:0], e_skip);
    end
    @(posedge clk);
    #1;
    tests++;
    if ({w_o, c_o, dc_o, z_o} !== {m_w, m_c, m_dc, m_z}) begin
      fails++;
      $display("FAIL %s state instr=%h a=%h: got w=%h c=%b dc=%b z=%b, exp w=%h c=%b dc=%b z=%b",
               req, ins, a, w_o, c_o, dc_o, z_o, m_w, m_c, m_dc, m_z);
    end
  endtask

  function automatic logic [7:0] wsel(int i);
    case (i)
      0: return 8'h00;
      1: return 8'h0F;
      2: return 8'h81;
      default: return 8'hFF;
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout, exp completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1: reset state
    tests++;
    if ({w_o, c_o, dc_o, z_o, wr_en_o, skip_o} !== 13'd0) begin
      fails++;
      $display("FAIL R1 reset: got w=%h c=%b dc=%b z=%b wen=%b skip=%b, exp all zero",
               w_o, c_o, dc_o, z_o, wr_en_o, skip_o);
    end

    // R2 R3 R4 R5 R6 R10: byte ops, all operands, four W values, both destinations
    for (int op = 2; op < 16; op++)
      for (int wi = 0; wi < 4; wi++)
        for (int a = 0; a < 256; a++) begin
          logic dbit;
          dbit = a[0] ^ wi[0];
          run({4'hC, wsel(wi)}, 8'h00, 1'b1);
          run({op[5:0], dbit, a[4:0] ^ 5'(wi)}, 8'(a), 1'b1);
        end

    // R8 R9: bit ops, all indices and operands
    for (int hi = 4; hi < 8; hi++)
      for (int b = 0; b < 8; b++)
        for (int a = 0; a < 256; a++)
          run({hi[3:0], b[2:0], a[4:0]}, 8'(a), 1'b1);

    // R11: literal ops
    for (int hi = 12; hi < 16; hi++)
      for (int wi = 0; wi < 4; wi++)
        for (int k = 0; k < 256; k++) begin
          run({4'hC, wsel(wi)}, 8'h00, 1'b1);
          run({hi[3:0], k[7:0]}, 8'h00, 1'b1);
        end

    // R6 R7: move W to file, clear file, clear W
    for (int a = 0; a < 32; a++) begin
      run({4'hC, 8'(a * 7 + 1)}, 8'h00, 1'b1);
      run({7'b0000001, a[4:0]}, 8'h55, 1'b1);
      run({4'hC, 8'h00}, 8'h00, 1'b1);
      run({4'hD, 8'h3C}, 8'h00, 1'b1);      // Z cleared
      run({7'b0000011, a[4:0]}, 8'(a + 9), 1'b1);
      run({4'hD, 8'h01}, 8'h00, 1'b1);
      run(12'h040, 8'hAA, 1'b1);
    end

    // R12: ignored words and idle cycles, with all flags set first
    run({4'hC, 8'h01}, 8'h00, 1'b1);
    run({6'b000111, 1'b0, 5'd3}, 8'hFF, 1'b1);   // C=DC=Z=1, W=0
    run({4'hC, 8'h6B}, 8'h00, 1'b1);
    for (int hi = 8; hi < 12; hi++)
      for (int k = 0; k < 256; k += 17)
        run({hi[3:0], k[7:0]}, 8'(k), 1'b1);
    run(12'h000, 8'h00, 1'b1);
    run(12'h002, 8'h12, 1'b1);
    run(12'h003, 8'h34, 1'b1);
    run(12'h004, 8'h56, 1'b1);
    run(12'h006, 8'h78, 1'b1);
    run(12'h041, 8'h9A, 1'b1);
    run(12'h05F, 8'hBC, 1'b1);
    for (int a = 0; a < 16; a++) begin
      run({6'b000111, 1'b1, a[4:0]}, 8'(a * 13), 1'b0);
      run({6'b001011, 1'b0, a[4:0]}, 8'h01, 1'b0);
      run({4'hC, 8'(a)}, 8'h00, 1'b0);
    end

    @(negedge clk);
    valid = 1'b0;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule